// File: doc/BRIEF.md
# LIN Slave Break Detector and Generator

This block sits beside a serial receiver and transmitter on a LIN slave node and handles the break symbol only. On the receive side it watches the line through a synchronizer, sampled on a 16x oversample tick. It counts how long the line stays dominant (low) in whole bit times and raises a sticky flag once that run reaches a selectable threshold. On the transmit side, a request strobe makes it drive a dominant break of selectable length, followed by one recessive bit, while a busy flag is held.

Two control inputs choose the behaviour. With both clear, the block uses a standard break: the detect threshold and the generated length both equal one character frame of all zeros. With the receive-filter input set, detection waits for an extended run. That run is long enough that a slave whose clock is off by up to 15% cannot mistake a 0x00 data byte for a break, since such a byte can stretch to about 10.35 bit times while a real break spans 11.05 to 14.95. With the extended-transmit input set, the generator emits 13- or 14-bit breaks. Both extensions may be active at once. The character-length input picks the longer value of each pair. Framing, identifier handling and software checking of the break length happen elsewhere.

Top module: `lin_brk_unit`

## Requirements
- R1: After reset brk_det is 0, busy is 0 and tx_o is 1 (recessive).
- R2: With filt_en=0, brk_det is set after 10 bit times (160 ticks) of continuous low when len9=0, or 11 bit times (176 ticks) when len9=1; one tick fewer does not set it.
- R3: With filt_en=1 and len9=0, brk_det is set after exactly 11 bit times (176 ticks) of continuous low; 175 ticks do not set it.
- R4: With filt_en=1 and len9=1, brk_det is set after exactly 12 bit times (192 ticks) of continuous low; 191 ticks do not set it.
- R5: A single high sample on rx_i before the threshold restarts the count, so two sub-threshold runs separated by one high tick never set brk_det.
- R6: brk_det stays 1 until brk_clr is pulsed high for one cycle, after which it reads 0.
- R7: After a detection, further low samples do not report again; one high sample is needed before the next run can set brk_det.
- R8: A brk_req pulse while idle drives tx_o low for N bit times (N*16 ticks), where N is 10/11 with xbrk_en=0 and 13/14 with xbrk_en=1, for len9=0/1.
- R9: After the low part of a break, tx_o stays high for exactly 16 ticks before busy returns to 0.
- R10: brk_req while busy is ignored: the running break keeps its length and no second break follows.
- R11: Detection and generation run at the same time; with tx_o looped to rx_i and filt_en=xbrk_en=1, a generated break sets brk_det, while a normal 10-bit break does not pass the 11-bit filter.
- R12: With filt_en=1 and len9=0, a zero character of 9 low bits (144 ticks), or one stretched to 165 ticks, does not set brk_det.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe, 16 per bit time |
| rx_i | input | 1 | Receive line, asynchronous |
| tx_o | output | 1 | Transmit line, low during a generated break |
| filt_en | input | 1 | Extended receive break filter enable |
| xbrk_en | input | 1 | Extended transmit break length enable |
| len9 | input | 1 | Character length select (0: 8 data bits, 1: 9 data bits) |
| brk_req | input | 1 | Strobe requesting a break on tx_o |
| brk_clr | input | 1 | Write-1 strobe clearing brk_det |
| brk_det | output | 1 | Sticky break-detected flag |
| busy | output | 1 | Break generation in progress |

## Verification
The bench sweeps every filter and length setting with low runs one tick short of the threshold and exactly at it. A design off by one sample or one bit would fail at that edge, and a design using the wrong threshold table would let a 165-tick zero byte through. It splits two long runs with one high sample, which catches a counter that is not cleared on a recessive sample. It keeps the line low after clearing the flag, which catches a detector that re-arms without a recessive edge. On the transmit side it counts low and tail ticks for all four lengths and fires a second request mid-break, so a generator that restarts or stacks breaks shows up in the counts.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  localparam int unsigned BIT_W = 4;
  typedef logic [BIT_W-1:0] bitcnt_t;

  typedef enum logic [1:0] {
    G_IDLE = 2'd0,
    G_LOW  = 2'd1,
    G_TAIL = 2'd2
  } gen_state_e;

  // bit times of low needed before a break is reported
  function automatic bitcnt_t det_bits(input logic filt, input logic m9);
    if (filt) return m9 ? bitcnt_t'(12) : bitcnt_t'(11);
    else      return m9 ? bitcnt_t'(11) : bitcnt_t'(10);
  endfunction

  // bit times of low driven for a generated break
  function automatic bitcnt_t gen_bits(input logic ext, input logic m9);
    if (ext) return m9 ? bitcnt_t'(14) : bitcnt_t'(13);
    else     return m9 ? bitcnt_t'(11) : bitcnt_t'(10);
  endfunction

endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[gi] <= 1'b1;
          else        stg_q[gi] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[gi] <= 1'b1;
          else        stg_q[gi] <= stg_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
  import lin_brk_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    rx_s,
  input  bitcnt_t thr,
  input  logic    clr,
  output logic    det
);
  localparam int unsigned SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [SUB_W-1:0] sub_q, sub_d;
  bitcnt_t          bits_q, bits_d;
  logic             armed_q, armed_d;
  logic             det_q, det_d;
  logic             set;

  always_comb begin
    sub_d   = sub_q;
    bits_d  = bits_q;
    armed_d = armed_q;
    set     = 1'b0;
    if (tick) begin
      if (rx_s) begin
        sub_d   = '0;
        bits_d  = '0;
        armed_d = 1'b1;
      end else if (armed_q) begin
        if (sub_q == SUB_LAST) begin
          sub_d = '0;
          if (bits_q == bitcnt_t'(thr - 1'b1)) begin
            set     = 1'b1;
            armed_d = 1'b0;
            bits_d  = '0;
          end else begin
            bits_d = bits_q + 1'b1;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
    end
    det_d = set | (det_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      bits_q  <= '0;
      armed_q <= 1'b1;
      det_q   <= 1'b0;
    end else begin
      sub_q   <= sub_d;
      bits_q  <= bits_d;
      armed_q <= armed_d;
      det_q   <= det_d;
    end
  end

  assign det = det_q;

  assert_set_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> (tick && !rx_s));
  assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q && !clr) |=> det_q);
  assert_no_rereport_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !set);
  assert_high_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rx_s) |=> (armed_q && bits_q == '0));
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
  import lin_brk_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    req,
  input  bitcnt_t len,
  output logic    tx,
  output logic    busy
);
  localparam int unsigned SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  gen_state_e       st_q, st_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  bitcnt_t          bits_q, bits_d;
  bitcnt_t          len_q, len_d;

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    bits_d = bits_q;
    len_d  = len_q;
    unique case (st_q)
      G_IDLE: begin
        if (req) begin
          st_d   = G_LOW;
          sub_d  = '0;
          bits_d = '0;
          len_d  = len;
        end
      end
      G_LOW: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            if (bits_q == bitcnt_t'(len_q - 1'b1)) begin
              st_d   = G_TAIL;
              bits_d = '0;
            end else begin
              bits_d = bits_q + 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      G_TAIL: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            st_d  = G_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: st_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= G_IDLE;
      sub_q  <= '0;
      bits_q <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      bits_q <= bits_d;
      len_q  <= len_d;
    end
  end

  assign tx   = (st_q != G_LOW);
  assign busy = (st_q != G_IDLE);

  assert_low_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx |-> busy);
  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && !tick) |=> ($stable(st_q) && $stable(len_q)));
  assert_tail_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(tx) && tx));
endmodule

// File: rtl/lin_brk_unit.sv
module lin_brk_unit
  import lin_brk_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic rx_i,
  output logic tx_o,
  input  logic filt_en,
  input  logic xbrk_en,
  input  logic len9,
  input  logic brk_req,
  input  logic brk_clr,
  output logic brk_det,
  output logic busy
);
  logic    rx_s;
  bitcnt_t det_thr;
  bitcnt_t gen_len;

  assign det_thr = det_bits(filt_en, len9);
  assign gen_len = gen_bits(xbrk_en, len9);

  lin_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  lin_brk_det #(.OVS(OVS)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (os_tick),
    .rx_s  (rx_s),
    .thr   (det_thr),
    .clr   (brk_clr),
    .det   (brk_det)
  );

  lin_brk_gen #(.OVS(OVS)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (os_tick),
    .req   (brk_req),
    .len   (gen_len),
    .tx    (tx_o),
    .busy  (busy)
  );

  assert_idle_recessive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_o);
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && !os_tick) |=> !brk_det);
endmodule

// File: tb/lin_brk_unit_tb.sv
module lin_brk_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, os_tick, rx_b, loop_en;
  logic filt_en, xbrk_en, len9, brk_req, brk_clr;
  logic tx_o, brk_det, busy;
  logic rx_i;
  assign rx_i = loop_en ? tx_o : rx_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  lin_brk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_i(rx_i), .tx_o(tx_o),
    .filt_en(filt_en), .xbrk_en(xbrk_en), .len9(len9), .brk_req(brk_req),
    .brk_clr(brk_clr), .brk_det(brk_det), .busy(busy)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic set_rx(input logic v);
    @(negedge clk) rx_b = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) brk_clr = 1'b1;
    @(negedge clk) brk_clr = 1'b0;
  endtask

  task automatic low_run(input int n);
    set_rx(1'b0);
    ticks(n);
    set_rx(1'b1);
    ticks(2);
  endtask

  task automatic pulse_req();
    @(negedge clk) brk_req = 1'b1;
    @(negedge clk) brk_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) tick1();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; os_tick = 1'b0; rx_b = 1'b1; loop_en = 1'b0;
    filt_en = 1'b0; xbrk_en = 1'b0; len9 = 1'b0; brk_req = 1'b0; brk_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(brk_det == 1'b0, "R1 brk_det", brk_det, 0);
    chk(busy == 1'b0,    "R1 busy",    busy,    0);
    chk(tx_o == 1'b1,    "R1 tx_o",    tx_o,    1);

    // R2 R3 R4 threshold sweep
    for (int f = 0; f < 2; f++) begin
      for (int m = 0; m < 2; m++) begin
        int thr;
        string tag;
        int lens [4];
        filt_en = f[0];
        len9    = m[0];
        thr = (f == 1) ? ((m == 1) ? 12 : 11) : ((m == 1) ? 11 : 10);
        tag = (f == 0) ? "R2" : ((m == 0) ? "R3" : "R4");
        lens[0] = thr * 16 - 1;
        lens[1] = thr * 16;
        lens[2] = thr * 16 + 5;
        lens[3] = 144;
        ticks(2);
        for (int k = 0; k < 4; k++) begin
          int exp;
          low_run(lens[k]);
          exp = (lens[k] >= thr * 16) ? 1 : 0;
          chk(brk_det == exp[0], tag, brk_det, exp);
          clear_flag();
          chk(brk_det == 1'b0, "R6 cleared", brk_det, 0);
        end
      end
    end

    // R12 stretched zero character in filter mode
    filt_en = 1'b1; len9 = 1'b0;
    low_run(165);
    chk(brk_det == 1'b0, "R12 165 ticks", brk_det, 0);
    low_run(144);
    chk(brk_det == 1'b0, "R12 144 ticks", brk_det, 0);

    // R5 one high sample restarts the count
    set_rx(1'b0); ticks(170);
    set_rx(1'b1); ticks(1);
    set_rx(1'b0); ticks(170);
    set_rx(1'b1); ticks(2);
    chk(brk_det == 1'b0, "R5 split run", brk_det, 0);

    // R6 sticky, R7 rearm
    set_rx(1'b0); ticks(176);
    chk(brk_det == 1'b1, "R3 detect mid-run", brk_det, 1);
    ticks(30);
    chk(brk_det == 1'b1, "R6 sticky", brk_det, 1);
    clear_flag();
    ticks(200);
    chk(brk_det == 1'b0, "R7 no rereport while low", brk_det, 0);
    set_rx(1'b1); ticks(2);
    low_run(176);
    chk(brk_det == 1'b1, "R7 rearmed", brk_det, 1);
    clear_flag();

    // R8 R9 R10 generator sweep
    filt_en = 1'b0;
    for (int x = 0; x < 2; x++) begin
      for (int m = 0; m < 2; m++) begin
        int nb, n, t, lows;
        xbrk_en = x[0];
        len9    = m[0];
        nb = (x == 1) ? ((m == 1) ? 14 : 13) : ((m == 1) ? 11 : 10);
        pulse_req();
        chk(busy == 1'b1 && tx_o == 1'b0, "R8 start", {busy, tx_o}, 2);
        ticks(20);
        pulse_req();
        n = 20;
        for (int i = 0; i < 400; i++) begin
          tick1();
          n++;
          if (tx_o) break;
        end
        chk(n == nb * 16, "R8 low ticks", n, nb * 16);
        t = 0;
        for (int i = 0; i < 100; i++) begin
          tick1();
          t++;
          if (!busy) break;
        end
        chk(t == 16, "R9 tail ticks", t, 16);
        chk(tx_o == 1'b1, "R9 tx high", tx_o, 1);
        lows = 0;
        for (int i = 0; i < 40; i++) begin
          tick1();
          if (!tx_o || busy) lows++;
        end
        chk(lows == 0, "R10 no second break", lows, 0);
      end
    end

    // R11 loopback, both directions active
    loop_en = 1'b1;
    filt_en = 1'b1; xbrk_en = 1'b1; len9 = 1'b0;
    ticks(2);
    pulse_req(); wait_idle(); ticks(2);
    chk(brk_det == 1'b1, "R11 13-bit vs 11-bit filter", brk_det, 1);
    clear_flag();
    len9 = 1'b1;
    pulse_req(); wait_idle(); ticks(2);
    chk(brk_det == 1'b1, "R11 14-bit vs 12-bit filter", brk_det, 1);
    clear_flag();
    xbrk_en = 1'b0; len9 = 1'b0;
    pulse_req(); wait_idle(); ticks(2);
    chk(brk_det == 1'b0, "R11 10-bit rejected by filter", brk_det, 0);
    loop_en = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule